// File: doc/BRIEF.md
# Raw Sensor Frame Packet Sequencer

This block paces the readout of one raw image frame after another for a serial camera transmitter. Each frame starts with a single-cycle frame-start strobe. Two embedded-data lines follow, carrying a parameterised list of register bytes. Then come the active Bayer pixel lines and one trailing auxiliary line, and a single-cycle frame-end strobe closes the frame. Idle gaps of programmable length separate the items. The line gaps use a line-blanking value and the gap after frame end uses a frame-blanking value.

The downstream packer learns which kind of line is in flight from a line-valid signal and a two-bit line-type tag. While a pixel line is running, a pixel-valid signal and a colour-phase code give the Bayer position of each pixel. The data output carries the embedded bytes on embedded lines. On pixel lines it carries a test pattern built from the row and column counters. The geometry mode and both blanking lengths are captured once per frame, when frame start is issued, so the host may change them at any time.

Top module: `sensor_frame_seq`

## Requirements
- R1: While reset is held, every output is zero. After reset is released, the first event is a frame start. No line or frame end comes before it.
- R2: Each frame is, in order: one frame-start cycle, exactly 2 embedded lines, the active pixel lines, exactly 1 auxiliary line, and one frame-end cycle. Frame start and frame end are each one cycle long and never coincide with line-valid.
- R3: In full mode a pixel line is FULL_COLS pixels and there are FULL_ROWS pixel lines. In binned mode (mode input 1) both counts are halved. Embedded and auxiliary lines have the same length as the pixel lines of that frame.
- R4: The mode and both blanking lengths are sampled only in the frame-start cycle. Changes at any other time have no effect until the next frame start.
- R5: The number of idle cycles is equal to the latched line-blanking value. This holds between frame start and the first line, between two lines, and between the last line and frame end. A value of 0 gives 1 idle cycle.
- R6: The idle gap from frame end to the next frame start is the frame-blanking value latched at the previous frame start, with 0 giving 1 cycle.
- R7: While line-valid is high, the line type is 0 on embedded lines, 1 on pixel lines and 2 on the auxiliary line. Pixel-valid is high only on pixel lines.
- R8: The colour phase is {row[0], col[0]}, with row and column counted from 0 at the first pixel line and first pixel. This gives 0=R, 1=Gr, 2=Gb, 3=B. Even rows alternate R/Gr and odd rows alternate Gb/B.
- R9: On pixel lines the data output is (row + col) modulo 1024.
- R10: On embedded lines, byte position p = line*width + col (line 0 or 1) carries register byte p of EMB_REGS when p < NUM_REGS, and FILLER otherwise. The data output is zero on the auxiliary line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| binned_i | input | 1 | Geometry mode: 0 full, 1 binned by two |
| line_blank_i | input | BLANK_W | Idle cycles between lines |
| frame_blank_i | input | BLANK_W | Idle cycles after frame end |
| frame_start_o | output | 1 | Frame-start strobe |
| frame_end_o | output | 1 | Frame-end strobe |
| line_valid_o | output | 1 | A line is in progress |
| line_type_o | output | 2 | 0 embedded, 1 pixel, 2 auxiliary |
| pixel_valid_o | output | 1 | Pixel present on a pixel line |
| color_o | output | 2 | Bayer phase 0 R, 1 Gr, 2 Gb, 3 B |
| data_o | output | 10 | Embedded byte or test-pattern value |

## Verification
Every output is decoded from the present state registers. A strobe, line tag, colour phase or data word therefore belongs to the cycle in which it is visible, and it does not lag its cause. Inputs affect behaviour from the cycle after the frame-start cycle in which they were seen. The bench drives its inputs just after each rising edge and reads outputs on the falling edge. It captures its expected mode and blanking values from the inputs it sees in the frame-start cycle. It measures each gap by counting idle falling-edge samples between observed events. Random changes of the inputs in the middle of a frame must not show up until the next frame start.

// File: rtl/sensor_frame_seq.sv
module sensor_frame_seq #(
  parameter int FULL_COLS = 4056,
  parameter int FULL_ROWS = 3040,
  parameter int BLANK_W   = 16,
  parameter int NUM_REGS  = 4,
  parameter logic [8*NUM_REGS-1:0] EMB_REGS = 32'h0A_03_31_00,
  parameter logic [7:0] FILLER = 8'h07
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               binned_i,
  input  logic [BLANK_W-1:0] line_blank_i,
  input  logic [BLANK_W-1:0] frame_blank_i,
  output logic               frame_start_o,
  output logic               frame_end_o,
  output logic               line_valid_o,
  output logic [1:0]         line_type_o,
  output logic               pixel_valid_o,
  output logic [1:0]         color_o,
  output logic [9:0]         data_o
);
  localparam int CW = $clog2(FULL_COLS + 1);
  localparam int LW = $clog2(FULL_ROWS + 4);

  typedef enum logic [2:0] {S_FBLK, S_FS, S_LBLK, S_LINE, S_FE} st_t;

  st_t                st;
  logic [BLANK_W-1:0] blk, lb_q, fb_q;
  logic [CW-1:0]      col;
  logic [LW-1:0]      line;
  logic               bin_q;

  logic [CW-1:0] cols_w;
  logic [LW-1:0] rows_w, aux_line, end_line, prow;
  logic          lb_done, fb_done, is_emb, is_aux;

  assign cols_w   = bin_q ? CW'(FULL_COLS / 2) : CW'(FULL_COLS);
  assign rows_w   = bin_q ? LW'(FULL_ROWS / 2) : LW'(FULL_ROWS);
  assign aux_line = rows_w + LW'(2);
  assign end_line = rows_w + LW'(3);
  assign lb_done  = ({1'b0, blk} + 1'b1) >= {1'b0, lb_q};
  assign fb_done  = ({1'b0, blk} + 1'b1) >= {1'b0, fb_q};

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      st    <= S_FBLK;
      blk   <= '0;
      col   <= '0;
      line  <= '0;
      bin_q <= 1'b0;
      lb_q  <= '0;
      fb_q  <= '0;
    end else begin
      case (st)
        S_FBLK: begin
          if (fb_done) begin
            st  <= S_FS;
            blk <= '0;
          end else blk <= blk + 1'b1;
        end
        S_FS: begin
          bin_q <= binned_i;
          lb_q  <= line_blank_i;
          fb_q  <= frame_blank_i;
          line  <= '0;
          blk   <= '0;
          st    <= S_LBLK;
        end
        S_LBLK: begin
          if (lb_done) begin
            blk <= '0;
            col <= '0;
            st  <= (line == end_line) ? S_FE : S_LINE;
          end else blk <= blk + 1'b1;
        end
        S_LINE: begin
          if (col == cols_w - CW'(1)) begin
            line <= line + 1'b1;
            st   <= S_LBLK;
          end else col <= col + 1'b1;
        end
        S_FE: begin
          blk <= '0;
          st  <= S_FBLK;
        end
        default: st <= S_FBLK;
      endcase
    end
  end

  assign frame_start_o = (st == S_FS);
  assign frame_end_o   = (st == S_FE);
  assign line_valid_o  = (st == S_LINE);
  assign is_emb        = line < LW'(2);
  assign is_aux        = line == aux_line;
  assign prow          = line - LW'(2);
  assign pixel_valid_o = line_valid_o && !is_emb && !is_aux;
  assign line_type_o   = !line_valid_o ? 2'd0 : is_emb ? 2'd0 : is_aux ? 2'd2 : 2'd1;
  assign color_o       = pixel_valid_o ? {prow[0], col[0]} : 2'd0;

  logic [31:0] emb_idx, pix_sum;
  logic [7:0]  emb_byte;
  assign emb_idx = 32'(line) * 32'(cols_w) + 32'(col);
  assign pix_sum = 32'(prow) + 32'(col);

  always_comb begin
    emb_byte = FILLER;
    for (int k = 0; k < NUM_REGS; k++)
      if (emb_idx == 32'(k)) emb_byte = EMB_REGS[k*8 +: 8];
  end

  assign data_o = pixel_valid_o ? pix_sum[9:0] :
                  (line_valid_o && is_emb) ? {2'b00, emb_byte} : 10'd0;
endmodule

// File: rtl/sensor_frame_seq_chk.sv
module sensor_frame_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fs,
  input logic       fe,
  input logic       lv,
  input logic [1:0] lt,
  input logic       pv,
  input logic [1:0] color,
  input logic       bin_q
);
  assert_pv_on_pixel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pv |-> (lv && lt == 2'd1));

  assert_type_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lv |-> (lt != 2'd3));

  assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fs || fe) |-> (!lv && !(fs && fe)));

  assert_fs_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fs |=> !fs);

  assert_fe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fe |=> (!fe && !fs));

  assert_mode_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bin_q) |-> $past(fs));

  assert_bayer_phase_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pv && $past(pv)) |-> (color[1] == $past(color[1]) && color[0] != $past(color[0])));
endmodule

bind sensor_frame_seq sensor_frame_seq_chk u_chk (
  .clk(clk_i), .rst_n(rst_ni), .fs(frame_start_o), .fe(frame_end_o),
  .lv(line_valid_o), .lt(line_type_o), .pv(pixel_valid_o), .color(color_o),
  .bin_q(bin_q)
);

// File: tb/tb_sensor_frame_seq.sv
module tb_sensor_frame_seq;
  localparam int COLS = 8, ROWS = 6, BW = 16, NREG = 10, FRAMES = 20;
  localparam logic [8*NREG-1:0] REGS = 80'hAA99_8877_6655_4433_2211;
  localparam logic [7:0] FILL = 8'h5C;

  logic clk = 0, rst_n = 0, binned = 0;
  logic [BW-1:0] lblank = '0, fblank = '0;
  logic fs, fe, lv, pv;
  logic [1:0] lt, color;
  logic [9:0] data;

  sensor_frame_seq #(.FULL_COLS(COLS), .FULL_ROWS(ROWS), .BLANK_W(BW),
    .NUM_REGS(NREG), .EMB_REGS(REGS), .FILLER(FILL)) dut (
    .clk_i(clk), .rst_ni(rst_n), .binned_i(binned), .line_blank_i(lblank),
    .frame_blank_i(fblank), .frame_start_o(fs), .frame_end_o(fe),
    .line_valid_o(lv), .line_type_o(lt), .pixel_valid_o(pv), .color_o(color),
    .data_o(data));

  always #4 clk = ~clk;

  int checks = 0, fails = 0, frames = 0, cyc = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic int exp_emb(input int p);
    return (p < NREG) ? ((p + 1) * 17) % 256 : int'(FILL);
  endfunction

  bit started = 0, in_frame = 0, in_line = 0, seen_fe = 0;
  int gap = 0, line_cnt = 0, col_cnt = 0;
  int e_cols = COLS, e_rows = ROWS, e_lb = 0, e_fb = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      chk({fs, fe, lv, pv, lt, color, data} == '0, "R1 reset outputs", int'(data), 0);
    end else begin
      cyc++;
      if (!started && (lv || fe))
        chk(0, "R1 first event not frame start", int'(lv), 0);
      if (in_line && !lv) begin
        chk(col_cnt == e_cols, "R3 line length", col_cnt, e_cols);
        line_cnt++;
        in_line = 0;
        gap = 0;
      end
      if (!fs && !fe && !lv) gap++;
      if (fs) begin
        if (seen_fe) chk(gap == eff(e_fb), "R6 frame blank", gap, eff(e_fb));
        chk(!in_frame, "R2 start inside frame", int'(in_frame), 0);
        started = 1;
        in_frame = 1;
        line_cnt = 0;
        gap = 0;
        e_cols = binned ? COLS / 2 : COLS;
        e_rows = binned ? ROWS / 2 : ROWS;
        e_lb = int'(lblank);
        e_fb = int'(fblank);
      end
      if (lv) begin
        int et;
        if (!in_line) begin
          chk(gap == eff(e_lb), "R5 gap before line", gap, eff(e_lb));
          chk(line_cnt <= e_rows + 2, "R2 too many lines", line_cnt, e_rows + 2);
          in_line = 1;
          col_cnt = 0;
        end
        et = (line_cnt < 2) ? 0 : (line_cnt == e_rows + 2) ? 2 : 1;
        chk(int'(lt) == et, "R7 line type", int'(lt), et);
        chk(pv == (et == 1), "R7 pixel valid", int'(pv), int'(et == 1));
        if (et == 1) begin
          int r, ec, ed;
          r = line_cnt - 2;
          ec = (r % 2) * 2 + (col_cnt % 2);
          ed = (r + col_cnt) % 1024;
          chk(int'(color) == ec, "R8 colour phase", int'(color), ec);
          chk(int'(data) == ed, "R9 pattern data", int'(data), ed);
        end else if (et == 0) begin
          int ed;
          ed = exp_emb(line_cnt * e_cols + col_cnt);
          chk(int'(data) == ed, "R10 embedded byte", int'(data), ed);
        end else begin
          chk(data == 10'd0, "R10 auxiliary data", int'(data), 0);
        end
        col_cnt++;
      end
      if (fe) begin
        chk(gap == eff(e_lb), "R5 gap before frame end", gap, eff(e_lb));
        chk(line_cnt == e_rows + 3, "R2 R3 line count", line_cnt, e_rows + 3);
        in_frame = 0;
        seen_fe = 1;
        gap = 0;
        frames++;
      end
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    while (frames < FRAMES && cyc < 100000) begin
      @(posedge clk);
      #1;
      if (frames == 2 && !fs) begin
        binned = 1; lblank = 16'd7; fblank = 16'd0;
      end else if (frames > 3 && $urandom_range(0, 7) == 0) begin
        binned = 1'($urandom_range(0, 1));
        lblank = BW'($urandom_range(0, 4));
        fblank = BW'($urandom_range(0, 6));
      end
    end
    if (frames < FRAMES) chk(0, "R2 watchdog frames", frames, FRAMES);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule